// File: doc/BRIEF.md
# Iterative Unsigned Integer Divider

This block divides one unsigned integer by another, one quotient bit per clock. A run-time mode input picks the algorithm. The first is the trial-subtract method, which puts the partial remainder back when a subtraction goes negative. The second is the add-or-subtract method, which never puts the remainder back inside an iteration and fixes the sign of the remainder once, at the end.

The datapath holds three registers:
- a partial-remainder register one bit wider than the operands, so that its sign is visible;
- a quotient register, which starts out holding the dividend;
- a divisor register.

Each iteration shifts the remainder and quotient left together as one register. It then adds or subtracts the divisor and shifts the new quotient bit in at the bottom.

A caller pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse. The results stay on the outputs until the next division completes. A zero divisor finishes at once with a flag set.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` pulse while idle with a non-zero divisor raises `busy` in the next cycle. `busy` and `done` are never high together.
- R3: With `mode`=0 (restoring), `done` rises exactly WIDTH clock edges after the edge that accepted `start`. At that point `quotient` = dividend / divisor and `remainder` = dividend mod divisor.
- R4: With `mode`=1 (non-restoring), the results are the same as in R3, and `done` rises WIDTH+1 edges after the accepting edge. The extra edge is the final remainder-correction step.
- R5: A zero divisor gives `done`=1 and `div_zero`=1 after the accepting edge itself. In that case `quotient` is all ones, `remainder` equals the dividend, and `busy` stays low.
- R6: `done` is high for one cycle only, unless a new zero-divisor `start` is accepted in that cycle. `quotient`, `remainder` and `div_zero` change only on a cycle in which `done` is high.
- R7: A `start` asserted while `busy` is high is ignored. The running division completes with its own operands.
- R8: For WIDTH=5, 21 / 5 gives quotient 4 and remainder 1 in both modes.
- R9: `mode`, `dividend` and `divisor` are sampled only on the accepting edge. Changing them mid-run alters neither result nor latency.
- R10: On every completion with `div_zero`=0, `remainder` is less than the divisor.
- R11: A completed division with a non-zero divisor clears a `div_zero` left by an earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only when not busy |
| mode | input | 1 | 0 = restoring, 1 = non-restoring |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Registered quotient |
| remainder | output | WIDTH | Registered remainder |
| div_zero | output | 1 | Last completion was a divide by zero |

## Verification
The hardest case to reach is the non-restoring run in which the remainder is still negative after the last iteration. Only then is the correction addition actually applied, and the ports give no sign of it. The stimulus sweeps every dividend and divisor pair of a 5-bit instance in both modes, so every operand pattern that ends negative is covered. Selected runs also pulse `start` mid-run, with different operands and the opposite mode, to show that the ignored request changes neither result nor latency.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

  typedef enum logic {
    MODE_RESTORE    = 1'b0,
    MODE_NONRESTORE = 1'b1
  } div_mode_e;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic nonrest,
  output logic busy,
  output logic step_en,
  output logic final_step,
  output logic fix_en
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  div_state_e      state;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= nonrest ? ST_FIX : ST_IDLE;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign step_en    = (state == ST_RUN);
  assign final_step = (state == ST_RUN) && (cnt == LAST);
  assign fix_en     = (state == ST_FIX);

  // R3
  iter_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cnt < CW'(N)));

  // R4
  fix_follows_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |=> (state == ST_IDLE));
endmodule

// File: rtl/div_step.sv
module div_step
  import div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N:0]   a_in,
  input  logic [N-1:0] q_in,
  input  logic [N-1:0] m_in,
  input  logic         nonrest,
  output logic [N:0]   a_out,
  output logic [N-1:0] q_out
);
  logic [N:0] shifted;
  logic [N:0] m_ext;
  logic [N:0] trial;
  logic       q_bit;

  always_comb begin
    shifted = {a_in[N-1:0], q_in[N-1]};
    m_ext   = {1'b0, m_in};
    if (nonrest) begin
      trial = a_in[N] ? (shifted + m_ext) : (shifted - m_ext);
      a_out = trial;
      q_bit = ~trial[N];
    end else begin
      trial = shifted - m_ext;
      a_out = trial[N] ? shifted : trial;
      q_bit = ~trial[N];
    end
    q_out = {q_in[N-2:0], q_bit};
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_zero
);
  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    a_q, a_nx, a_fixed;
  logic [WIDTH-1:0] q_q, q_nx, m_q;
  div_mode_e        mode_q;
  logic             accept, zero_div, go;
  logic             step_en, final_step, fix_en;

  assign accept   = start && !busy;
  assign zero_div = (divisor == '0);
  assign go       = accept && !zero_div;
  assign a_fixed  = a_q[AW-1] ? (a_q + {1'b0, m_q}) : a_q;

  div_ctrl #(.N(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .nonrest    (mode_q == MODE_NONRESTORE),
    .busy       (busy),
    .step_en    (step_en),
    .final_step (final_step),
    .fix_en     (fix_en)
  );

  div_step #(.N(WIDTH)) u_step (
    .a_in    (a_q),
    .q_in    (q_q),
    .m_in    (m_q),
    .nonrest (mode_q == MODE_NONRESTORE),
    .a_out   (a_nx),
    .q_out   (q_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      q_q       <= '0;
      m_q       <= '0;
      mode_q    <= MODE_RESTORE;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (zero_div) begin
          done      <= 1'b1;
          div_zero  <= 1'b1;
          quotient  <= '1;
          remainder <= dividend;
        end else begin
          a_q    <= '0;
          q_q    <= dividend;
          m_q    <= divisor;
          mode_q <= div_mode_e'(mode);
        end
      end
      if (step_en) begin
        a_q <= a_nx;
        q_q <= q_nx;
        if (final_step && mode_q == MODE_RESTORE) begin
          done      <= 1'b1;
          div_zero  <= 1'b0;
          quotient  <= q_nx;
          remainder <= a_nx[WIDTH-1:0];
        end
      end
      if (fix_en) begin
        a_q       <= a_fixed;
        done      <= 1'b1;
        div_zero  <= 1'b0;
        quotient  <= q_q;
        remainder <= a_fixed[WIDTH-1:0];
      end
    end
  end

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || $past(start)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  // R10
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero) |-> (remainder < m_q));

  // R5
  zero_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> (&quotient));

  // R3
  restore_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == MODE_RESTORE) |-> !a_q[AW-1]);
endmodule

// File: tb/seq_divider_bench.sv
`timescale 1ns/1ps
module seq_divider_bench;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_zero;
  logic [W-1:0] quotient, remainder;

  int total = 0;
  int bad = 0;
  int last_edges = 0;

  always #2 clk = ~clk;

  seq_divider #(.WIDTH(W)) u_seq_divider (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_div(input int dvd, input int dvs, input int md, input bit disturb);
    int exp_q, exp_r, exp_e, edges;
    string tag;
    logic [W-1:0] hold_q;
    @(negedge clk);
    start = 1'b1; dividend = W'(dvd); divisor = W'(dvs); mode = md[0];
    @(negedge clk);
    start = 1'b0;
    edges = 0;
    if (dvs != 0) chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    while (!done && edges < 40) begin
      if (disturb && edges == 1) begin
        start = 1'b1; mode = ~md[0];
        dividend = W'(dvd) ^ '1; divisor = W'(1);
      end
      @(negedge clk);
      start = 1'b0;
      edges++;
    end
    last_edges = edges;
    if (dvs == 0) begin
      exp_q = (1 << W) - 1; exp_r = dvd; exp_e = 0; tag = "R5";
    end else begin
      exp_q = dvd / dvs; exp_r = dvd % dvs;
      exp_e = (md != 0) ? W + 1 : W;
      tag = (md != 0) ? "R4" : "R3";
    end
    if (disturb) tag = "R7";
    chk(done == 1'b1, {tag, " done"}, int'(done), 1);
    chk(int'(quotient) == exp_q, {tag, " quotient"}, int'(quotient), exp_q);
    chk(int'(remainder) == exp_r, {tag, " remainder"}, int'(remainder), exp_r);
    chk(div_zero == (dvs == 0), {tag, " div_zero"}, int'(div_zero), int'(dvs == 0));
    chk(edges == exp_e, {tag, " latency"}, edges, exp_e);
    hold_q = quotient;
    @(negedge clk);
    chk(done == 1'b0, "R6 pulse", int'(done), 0);
    @(negedge clk);
    chk(quotient == hold_q, "R6 hold", int'(quotient), int'(hold_q));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", int'(busy), 0);
    chk(done == 0, "R1 done", int'(done), 0);
    chk(div_zero == 0, "R1 div_zero", int'(div_zero), 0);
    chk(quotient == 0, "R1 quotient", int'(quotient), 0);
    chk(remainder == 0, "R1 remainder", int'(remainder), 0);

    // R8 worked example in both modes
    for (int md = 0; md < 2; md++) begin
      do_div(21, 5, md, 1'b0);
      chk(quotient == 5'd4, "R8 quotient", int'(quotient), 4);
      chk(remainder == 5'd1, "R8 remainder", int'(remainder), 1);
    end

    // R11 divide-by-zero flag cleared by next good run
    do_div(9, 0, 0, 1'b0);
    do_div(7, 2, 1, 1'b0);
    chk(div_zero == 0, "R11 div_zero", int'(div_zero), 0);

    // R7 / R9 mid-run start with other operands and opposite mode
    for (int md = 0; md < 2; md++) begin
      do_div(29, 3, md, 1'b1);
      chk(last_edges == ((md != 0) ? W + 1 : W), "R9 latency", last_edges,
          (md != 0) ? W + 1 : W);
    end

    // Exhaustive sweep, both modes (R3, R4, R5, R10)
    for (int md = 0; md < 2; md++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++) begin
          do_div(a, b, md, 1'b0);
          if (b != 0) chk(int'(remainder) < b, "R10 rem<div", int'(remainder), b);
        end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule